// File: doc/BRIEF.md
# Dual TAP Pin Selector

One set of JTAG pins is shared between two IEEE 1149.1 test access port controllers inside the chip. Controller 0 runs boundary scan; controller 1 runs emulation and debug. Only one of them owns the pins at a time. The owner is chosen by a mode pin, and the block samples that pin when the active-low test reset is released. The choice then holds until the next release of that reset.

The selected controller receives TMS and TDI directly. Its serial output and its output enable go to the TDO pin. The other controller sees TMS forced high and TDI forced low, so it stays in Test-Logic-Reset. Both controllers are small standard TAPs. Each has a state machine, a parameterised instruction register, a one-bit bypass register and a 32-bit IDCODE register. Both run from the shared TCK. TDO changes only on the falling edge of TCK.

The emulation controller is chosen when the mode pin is left at its pulled-up level. A board that needs boundary scan must hold the mode pin low while the reset is released.

Top module: `dual_tap_sel`

## Requirements
- R1: While `trst_n` is low, `tdo_oe` is 0 at once (asynchronously), and both controllers are held in Test-Logic-Reset.
- R2: A `mode_pin` value of 0 sampled at the rising edge of `trst_n` connects the boundary-scan controller. Its IDCODE (default 32'h1B5C_A0D3) is then returned by a data-register scan.
- R3: A `mode_pin` value of 1 sampled at the rising edge of `trst_n` connects the emulation controller. Its IDCODE (default 32'h2E3A_1001) is then returned by a data-register scan.
- R4: After the `trst_n` rising edge, changes on `mode_pin` have no effect on which controller is connected. The selection changes only at the next rising edge of `trst_n`.
- R5: The controller that is not selected stays in Test-Logic-Reset. It never affects `tdo` or `tdo_oe`.
- R6: `tdo_oe` is 1 only while the selected controller is in Shift-DR or Shift-IR. It changes on the falling edge of `tck`. `tdo` is 0 whenever `tdo_oe` is 0.
- R7: After reset, the instruction is IDCODE (code 4'b0010 by default). A data-register scan shifts out the 32-bit IDCODE, least significant bit first.
- R8: Any instruction other than the IDCODE code selects the one-bit bypass register. A scan returns 0 first and then each TDI bit delayed by one TCK.
- R9: In Capture-IR, the instruction shift register loads 01 in its two low bits and zeros above. An instruction scan therefore shifts out 1, 0, 0, ... first.
- R10: Five or more TCK cycles with TMS high reach Test-Logic-Reset from any state, and this restores the IDCODE instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock shared by both controllers |
| trst_n | input | 1 | Active-low test reset; its rising edge samples the mode pin |
| tms | input | 1 | Test mode select from the pin |
| tdi | input | 1 | Test data in from the pin |
| mode_pin | input | 1 | Owner select: 0 for boundary scan, 1 for emulation (pulled up on the board) |
| tdo | output | 1 | Test data out, launched on the falling edge of TCK |
| tdo_oe | output | 1 | Output enable for the TDO pad driver |

## Verification
On every TCK cycle the assertions check four things. The unselected controller sits in Test-Logic-Reset. The selection register never moves between resets. `tdo_oe` follows the shift states of the selected controller. `tdo` stays quiet when it is not enabled. Only the bench's scenarios can show the rest, because it needs a full scan sequence driven at the pins. That covers which IDCODE appears for each sampled mode value, the bypass delay, the capture pattern of the instruction register, and the return to IDCODE after a TMS-high walk.

// File: rtl/dual_tap_pkg.sv
package dual_tap_pkg;

    typedef enum logic [3:0] {
        TS_TLR    = 4'hF,
        TS_RTI    = 4'hC,
        TS_SELDR  = 4'h7,
        TS_CAPDR  = 4'h6,
        TS_SHDR   = 4'h2,
        TS_EX1DR  = 4'h1,
        TS_PAUDR  = 4'h3,
        TS_EX2DR  = 4'h0,
        TS_UPDDR  = 4'h5,
        TS_SELIR  = 4'h4,
        TS_CAPIR  = 4'hE,
        TS_SHIR   = 4'hA,
        TS_EX1IR  = 4'h9,
        TS_PAUIR  = 4'hB,
        TS_EX2IR  = 4'h8,
        TS_UPDIR  = 4'hD
    } tap_state_e;

    localparam int unsigned ID_W = 32;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TS_TLR:   n = m ? TS_TLR   : TS_RTI;
            TS_RTI:   n = m ? TS_SELDR : TS_RTI;
            TS_SELDR: n = m ? TS_SELIR : TS_CAPDR;
            TS_CAPDR: n = m ? TS_EX1DR : TS_SHDR;
            TS_SHDR:  n = m ? TS_EX1DR : TS_SHDR;
            TS_EX1DR: n = m ? TS_UPDDR : TS_PAUDR;
            TS_PAUDR: n = m ? TS_EX2DR : TS_PAUDR;
            TS_EX2DR: n = m ? TS_UPDDR : TS_SHDR;
            TS_UPDDR: n = m ? TS_SELDR : TS_RTI;
            TS_SELIR: n = m ? TS_TLR   : TS_CAPIR;
            TS_CAPIR: n = m ? TS_EX1IR : TS_SHIR;
            TS_SHIR:  n = m ? TS_EX1IR : TS_SHIR;
            TS_EX1IR: n = m ? TS_UPDIR : TS_PAUIR;
            TS_PAUIR: n = m ? TS_EX2IR : TS_PAUIR;
            TS_EX2IR: n = m ? TS_UPDIR : TS_SHIR;
            TS_UPDIR: n = m ? TS_SELDR : TS_RTI;
            default:  n = TS_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_core.sv
module tap_core
    import dual_tap_pkg::*;
#(
    parameter int unsigned       IR_W   = 4,
    parameter logic [IR_W-1:0]   ID_INS = 4'b0010,
    parameter logic [ID_W-1:0]   IDCODE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    output tap_state_e state_o,
    output logic       so_o,
    output logic       shift_o
);

    localparam logic [IR_W-1:0] IR_CAPT = {{(IR_W-2){1'b0}}, 2'b01};

    typedef struct packed {
        tap_state_e      st;
        logic [IR_W-1:0] ir_sr;
        logic [IR_W-1:0] ir;
        logic [ID_W-1:0] dr_sr;
    } core_t;

    core_t c_d, c_q;
    logic  use_id;

    always_comb begin
        c_d    = c_q;
        use_id = (c_q.ir == ID_INS);
        c_d.st = tap_next(c_q.st, tms);
        case (c_q.st)
            TS_TLR:   c_d.ir    = ID_INS;
            TS_CAPIR: c_d.ir_sr = IR_CAPT;
            TS_SHIR:  c_d.ir_sr = {tdi, c_q.ir_sr[IR_W-1:1]};
            TS_UPDIR: c_d.ir    = c_q.ir_sr;
            TS_CAPDR: c_d.dr_sr = use_id ? IDCODE : '0;
            TS_SHDR: begin
                if (use_id) c_d.dr_sr    = {tdi, c_q.dr_sr[ID_W-1:1]};
                else        c_d.dr_sr[0] = tdi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            c_q.st    <= TS_TLR;
            c_q.ir_sr <= '0;
            c_q.ir    <= ID_INS;
            c_q.dr_sr <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o = c_q.st;
    assign shift_o = (c_q.st == TS_SHDR) || (c_q.st == TS_SHIR);
    assign so_o    = (c_q.st == TS_SHIR) ? c_q.ir_sr[0] : c_q.dr_sr[0];

endmodule

// File: rtl/dual_tap_sel.sv
module dual_tap_sel
    import dual_tap_pkg::*;
#(
    parameter int unsigned      IR_W     = 4,
    parameter logic [IR_W-1:0]  ID_INS   = 4'b0010,
    parameter logic [ID_W-1:0]  ID_BSCAN = 32'h1B5C_A0D3,
    parameter logic [ID_W-1:0]  ID_EMU   = 32'h2E3A_1001
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic mode_pin,
    output logic tdo,
    output logic tdo_oe
);

    localparam int unsigned N_TAP = 2;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_t;

    logic       sel_d, sel_q;
    tap_state_e st_w  [N_TAP];
    logic       so_w  [N_TAP];
    logic       sh_w  [N_TAP];
    logic       tms_w [N_TAP];
    logic       tdi_w [N_TAP];
    pin_t       pin_d, pin_q;

    // Owner chosen at reset release, fixed until the next release
    always_comb sel_d = mode_pin;

    always_ff @(posedge trst_n) begin
        sel_q <= sel_d;
    end

    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        localparam logic [ID_W-1:0] IDC = (g == 0) ? ID_BSCAN : ID_EMU;
        assign tms_w[g] = (sel_q == 1'(g)) ? tms : 1'b1;
        assign tdi_w[g] = (sel_q == 1'(g)) ? tdi : 1'b0;
        tap_core #(
            .IR_W   (IR_W),
            .ID_INS (ID_INS),
            .IDCODE (IDC)
        ) tap_i (
            .tck     (tck),
            .trst_n  (trst_n),
            .tms     (tms_w[g]),
            .tdi     (tdi_w[g]),
            .state_o (st_w[g]),
            .so_o    (so_w[g]),
            .shift_o (sh_w[g])
        );
    end

    always_comb begin
        pin_d.oe  = sh_w[sel_q];
        pin_d.dat = sh_w[sel_q] & so_w[sel_q];
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) pin_q <= '0;
        else         pin_q <= pin_d;
    end

    assign tdo    = pin_q.dat;
    assign tdo_oe = pin_q.oe;

endmodule

// File: rtl/dual_tap_sel_chk.sv
module dual_tap_sel_chk
    import dual_tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       sel,
    input tap_state_e st_bs,
    input tap_state_e st_emu,
    input logic       tdo,
    input logic       tdo_oe
);

    logic       arm_q;
    tap_state_e st_on, st_off;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) arm_q <= 1'b0;
        else         arm_q <= 1'b1;
    end

    assign st_on  = sel ? st_emu : st_bs;
    assign st_off = sel ? st_bs  : st_emu;

    p_unsel_tlr_r5: assert property (@(posedge tck) disable iff (!trst_n)
        st_off == TS_TLR);

    p_sel_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        arm_q |-> $stable(sel));

    p_oe_shift_r6: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((st_on == TS_SHDR) || (st_on == TS_SHIR)));

    p_quiet_tdo_r6: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

    p_tlr_hiz_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (st_on == TS_TLR) |-> !tdo_oe);

endmodule

bind dual_tap_sel dual_tap_sel_chk chk_i (
    .tck    (tck),
    .trst_n (trst_n),
    .sel    (sel_q),
    .st_bs  (st_w[0]),
    .st_emu (st_w[1]),
    .tdo    (tdo),
    .tdo_oe (tdo_oe)
);

// File: tb/dual_tap_sel_tb_top.sv
module dual_tap_sel_tb_top;

    localparam logic [31:0] ID_BS  = 32'h1B5C_A0D3;
    localparam logic [31:0] ID_EM  = 32'h2E3A_1001;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, mode_pin = 1'b1;
    logic tdo, tdo_oe;
    int   n_run = 0, n_fail = 0;

    dual_tap_sel dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .mode_pin(mode_pin), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    always #2 tck = ~tck;

    function automatic logic [31:0] exp_id(input bit m);
        return m ? ID_EM : ID_BS;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Sample output for current state, then present TMS/TDI for the next rising edge
    task automatic step(input bit t, input bit d, output bit o, output bit e);
        @(negedge tck); #1;
        o = tdo; e = tdo_oe;
        tms = t; tdi = d;
        @(posedge tck);
    endtask

    task automatic do_reset(input bit m);
        @(negedge tck); #1;
        trst_n = 1'b0; tms = 1'b1; mode_pin = m;
        #1 chk("R1 oe low in reset", 32'(tdo_oe), 32'd0);
        repeat (2) @(negedge tck);
        #1 trst_n = 1'b1;
        @(posedge tck); #1;
        mode_pin = ~m;   // later changes must be ignored (R4)
    endtask

    task automatic to_rti();
        bit o, e;
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [31:0] din,
                        output logic [31:0] dout, output bit oe_ok);
        bit o, e;
        dout = '0; oe_ok = 1'b1;
        step(1'b1, 1'b0, o, e); oe_ok &= !e;
        if (is_ir) begin step(1'b1, 1'b0, o, e); oe_ok &= !e; end
        step(1'b0, 1'b0, o, e); oe_ok &= !e;
        step(1'b0, 1'b0, o, e); oe_ok &= !e;
        for (int i = 0; i < n; i++) begin
            step((i == n - 1), din[i], o, e);
            dout[i] = o; oe_ok &= e;
        end
        step(1'b1, 1'b0, o, e); oe_ok &= !e;
        step(1'b0, 1'b0, o, e); oe_ok &= !e;
    endtask

    initial begin
        logic [31:0] got, din;
        bit ok, o, e, m;
        void'($urandom(32'd20240611));
        #5;

        // Directed: both mode values
        do_reset(1'b0); to_rti();
        scan(1'b0, 32, 32'h0, got, ok);
        chk("R2 bscan idcode (R5 other quiet)", got, ID_BS);
        chk("R6 oe only in shift", 32'(ok), 32'd1);

        do_reset(1'b1); to_rti();
        scan(1'b0, 32, 32'h0, got, ok);
        chk("R3 emu idcode", got, ID_EM);

        // Directed: reset mid-shift drops oe at once
        step(1'b1, 1'b0, o, e); step(1'b0, 1'b0, o, e); step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        chk("R6 oe high in shift", 32'(e), 32'd1);
        #1 trst_n = 1'b0;
        #0.5 chk("R1 async oe drop", 32'(tdo_oe), 32'd0);

        // Random rounds
        for (int k = 0; k < 8; k++) begin
            m = 1'($urandom % 2);
            do_reset(m); to_rti();
            scan(1'b0, 32, 32'h0, got, ok);
            chk((m ? "R3/R4 idcode after mode flip" : "R2/R4 idcode after mode flip"), got, exp_id(m));
            chk("R7 idcode after reset", got, exp_id(m));

            scan(1'b1, 4, 32'hF, got, ok);
            chk("R9 ir capture", got & 32'hF, 32'h1);
            chk("R6 oe in shift-ir", 32'(ok), 32'd1);

            din = 32'($urandom) & 32'hFFFF;
            scan(1'b0, 16, din, got, ok);
            chk("R8 bypass", got, {din[14:0], 1'b0} & 32'hFFFF);

            for (int j = 0; j < int'($urandom % 20); j++) step(1'($urandom % 2), 1'b0, o, e);
            for (int j = 0; j < 5; j++) step(1'b1, 1'b0, o, e);
            chk("R10 oe off in TLR", 32'(tdo_oe), 32'd0);
            to_rti();
            scan(1'b0, 32, 32'h0, got, ok);
            chk("R10 idcode restored", got, exp_id(m));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule